// File: doc/BRIEF.md
# Byte-Coded Multi-Cycle 8-bit Processor Core

The block is a compact 8-bit processor that reads a program of byte-wide instructions from an external memory through a 16-bit address port and executes it until it stops. Each instruction begins with a one-byte opcode. Most opcodes are followed by two more bytes that carry register indices, an immediate value or a jump address. The core holds four 8-bit working registers, a 16-bit program counter, a 16-bit stack pointer that only resets, a zero flag and a carry flag.

A sequencer steps through fetch, opcode, first-operand and second-operand states and makes at most one memory read per state. The memory port is a plain synchronous read: the core raises the read strobe with an address, and the byte is returned on the next rising edge. The port has no back-pressure, so the memory must always answer with that fixed one-cycle latency. All architectural state is brought out on status outputs so that a surrounding environment can observe it.

Top module: `byte_cpu`

## Requirements
- R1: While reset is asserted, all four registers, the program counter, the stack pointer, both flags, the halted output and the error output read zero.
- R2: The opcode byte values are 0x01 load-immediate, 0x02 add, 0x03 subtract, 0x04 jump, 0x05 jump-if-zero and 0xFF halt. All except halt are three bytes long. The program counter advances by one for every byte read.
- R3: Load-immediate takes a destination index byte and then a data byte, and writes the data byte into that register. Indices 0..3 select registers whose values appear on `regs_o` bits [8i+7:8i]. An index above 3 writes nothing. The flags are left unchanged.
- R4: Add and subtract take a destination index byte and then a source index byte. They write dest+src or dest-src modulo 256 back to the destination. The zero flag is set exactly when the 8-bit result is 0. The carry flag is the unsigned overflow for add and the borrow for subtract.
- R5: If either index of an add or subtract is above 3, the result is 0 and carry is cleared, so zero is set. A destination index of 0..3 still receives that 0.
- R6: Jump takes the target address low byte first, then the high byte, and continues at that address.
- R7: Jump-if-zero loads its target only while the zero flag is set. Otherwise execution continues at the following instruction.
- R8: Halt sets the halted output. From then on no memory read is issued, and registers, flags and program counter stay frozen until reset.
- R9: Any other opcode value sets both halted and error. The program counter is left one past the offending byte.
- R10: Read data is due on the edge after the strobe. A three-byte instruction takes 4 cycles, and halt or an illegal opcode takes 2 cycles from its fetch until halted is visible. The first read, at address 0, is issued in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Read address (the program counter) |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Byte returned one edge after the strobe |
| regs_o | output | 32 | Registers, index i at bits [8i+7:8i] |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry / borrow flag |
| halted_o | output | 1 | Core stopped |
| error_o | output | 1 | Stopped on an illegal opcode |

## Verification
Every memory byte is due one rising edge after its strobe. Each three-byte instruction therefore completes four edges after its fetch, and halt or an illegal opcode shows on `halted_o` two edges after its fetch. The bench drives and samples on falling edges and counts rising edges from the release of reset. It compares the edge on which halted first appears with the total cycle count of its own instruction model, and checks final registers, flags and program counter at that point. For frozen-state checks it holds for a further ten edges and confirms that no read strobe appeared and that nothing moved.

// File: rtl/byte_cpu_pkg.sv
package byte_cpu_pkg;
  typedef enum logic [7:0] {
    OP_LOAD = 8'h01,
    OP_ADD  = 8'h02,
    OP_SUB  = 8'h03,
    OP_JMP  = 8'h04,
    OP_JZ   = 8'h05,
    OP_HALT = 8'hFF
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_OPC,
    ST_OP1,
    ST_OP2,
    ST_STOP
  } state_e;

  function automatic logic op_legal(input logic [7:0] b);
    return (b == OP_LOAD) || (b == OP_ADD) || (b == OP_SUB) ||
           (b == OP_JMP) || (b == OP_JZ) || (b == OP_HALT);
  endfunction
endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [DATA_W-1:0]          widx,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [DATA_W-1:0]          ridx_a,
  input  logic [DATA_W-1:0]          ridx_b,
  output logic [DATA_W-1:0]          rdata_a,
  output logic [DATA_W-1:0]          rdata_b,
  output logic                       ok_a,
  output logic                       ok_b,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= '0;
      else if (we && widx == DATA_W'(g)) regs[g] <= wdata;
    end
    assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
  end

  assign ok_a = ridx_a < DATA_W'(NUM_REGS);
  assign ok_b = ridx_b < DATA_W'(NUM_REGS);

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ridx_a == DATA_W'(i)) rdata_a = regs[i];
      if (ridx_b == DATA_W'(i)) rdata_b = regs[i];
    end
  end

  // R3: a write with an index beyond the file changes no register
  assert_oob_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx >= DATA_W'(NUM_REGS)) |=> $stable(regs_flat));
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu #(
  parameter int DATA_W = 8
) (
  input  logic              sub,
  input  logic              ok,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              carry
);
  logic [DATA_W:0] wide;

  always_comb begin
    if (!ok)      wide = '0;
    else if (sub) wide = {1'b0, a} - {1'b0, b};
    else          wide = {1'b0, a} + {1'b0, b};
  end

  assign res   = wide[DATA_W-1:0];
  assign carry = wide[DATA_W];
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
  import byte_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic [DATA_W-1:0] op1,
  output logic              alu_sub,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_carry,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              zf,
  output logic              cf,
  output logic              halted,
  output logic              error
);
  state_e            state_q;
  logic [DATA_W-1:0] opc_q;

  always_comb begin
    mem_rd   = 1'b0;
    rf_we    = 1'b0;
    rf_wdata = mem_rdata;
    alu_sub  = (opc_q == OP_SUB);
    case (state_q)
      ST_FETCH: mem_rd = 1'b1;
      ST_OPC:   mem_rd = op_legal(mem_rdata) && (mem_rdata != OP_HALT);
      ST_OP1:   mem_rd = 1'b1;
      ST_OP2: begin
        if (opc_q == OP_LOAD) rf_we = 1'b1;
        if (opc_q == OP_ADD || opc_q == OP_SUB) begin
          rf_we    = 1'b1;
          rf_wdata = alu_res;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc      <= '0;
      sp      <= '0;
      opc_q   <= '0;
      op1     <= '0;
      zf      <= 1'b0;
      cf      <= 1'b0;
      halted  <= 1'b0;
      error   <= 1'b0;
    end else begin
      if (mem_rd) pc <= pc + ADDR_W'(1);
      case (state_q)
        ST_FETCH: state_q <= ST_OPC;
        ST_OPC: begin
          opc_q <= mem_rdata;
          if (mem_rdata == OP_HALT) begin
            halted  <= 1'b1;
            state_q <= ST_STOP;
          end else if (!op_legal(mem_rdata)) begin
            halted  <= 1'b1;
            error   <= 1'b1;
            state_q <= ST_STOP;
          end else begin
            state_q <= ST_OP1;
          end
        end
        ST_OP1: begin
          op1     <= mem_rdata;
          state_q <= ST_OP2;
        end
        ST_OP2: begin
          if (opc_q == OP_ADD || opc_q == OP_SUB) begin
            zf <= (alu_res == '0);
            cf <= alu_carry;
          end
          if (opc_q == OP_JMP || (opc_q == OP_JZ && zf))
            pc <= ADDR_W'({mem_rdata, op1});
          state_q <= ST_FETCH;
        end
        default: state_q <= ST_STOP;
      endcase
    end
  end

  // R8: once stopped, nothing architectural moves
  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc) && $stable(zf) && $stable(cf));
  // R8: no memory traffic while stopped
  assert_no_read_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_rd);
  // R9: error only ever appears together with halted
  assert_error_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> halted);
  // R2: each byte read advances the program counter by one
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> pc == $past(pc) + ADDR_W'(1));
endmodule

// File: rtl/byte_cpu.sv
module byte_cpu #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic                       mem_rd,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic [ADDR_W-1:0]          pc_o,
  output logic [ADDR_W-1:0]          sp_o,
  output logic                       zero_o,
  output logic                       carry_o,
  output logic                       halted_o,
  output logic                       error_o
);
  logic [DATA_W-1:0] op1, rd_a, rd_b, alu_res, rf_wdata;
  logic              ok_a, ok_b, alu_sub, alu_carry, rf_we;

  cpu_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
    .pc(pc_o), .sp(sp_o), .op1(op1), .alu_sub(alu_sub), .alu_res(alu_res),
    .alu_carry(alu_carry), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .zf(zero_o), .cf(carry_o), .halted(halted_o), .error(error_o)
  );

  cpu_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .widx(op1), .wdata(rf_wdata),
    .ridx_a(op1), .ridx_b(mem_rdata), .rdata_a(rd_a), .rdata_b(rd_b),
    .ok_a(ok_a), .ok_b(ok_b), .regs_flat(regs_o)
  );

  cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .sub(alu_sub), .ok(ok_a && ok_b), .a(rd_a), .b(rd_b),
    .res(alu_res), .carry(alu_carry)
  );

  assign mem_addr = pc_o;
endmodule

// File: tb/sim_byte_cpu.sv
module sim_byte_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata = 8'h00;
  logic [31:0] regs_o;
  logic [15:0] pc_o, sp_o;
  logic        zero_o, carry_o, halted_o, error_o;

  byte_cpu u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .regs_o(regs_o), .pc_o(pc_o), .sp_o(sp_o),
    .zero_o(zero_o), .carry_o(carry_o), .halted_o(halted_o), .error_o(error_o)
  );

  always #10 clk = ~clk;

  logic [7:0] mem [4096];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];

  int n_chk = 0, n_fail = 0, wd = 0;

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench instruction model
  logic [7:0]  m_r [4];
  logic [15:0] m_pc;
  logic        m_z, m_c, m_h, m_e;
  int          m_cyc;

  function automatic logic [31:0] m_regs();
    return {m_r[3], m_r[2], m_r[1], m_r[0]};
  endfunction

  task automatic model_run();
    logic [7:0] op, b1, b2, res;
    logic [8:0] w;
    for (int i = 0; i < 4; i++) m_r[i] = 8'h00;
    m_pc = 0; m_z = 0; m_c = 0; m_h = 0; m_e = 0; m_cyc = 0;
    while (!m_h && m_cyc < 3000) begin
      op = mem[m_pc[11:0]]; m_pc++;
      if (op == 8'hFF) begin m_h = 1; m_cyc += 2; end
      else if (op >= 8'h01 && op <= 8'h05) begin
        b1 = mem[m_pc[11:0]]; m_pc++;
        b2 = mem[m_pc[11:0]]; m_pc++;
        m_cyc += 4;
        case (op)
          8'h01: if (b1 < 4) m_r[b1[1:0]] = b2;
          8'h02, 8'h03: begin
            if (b1 < 4 && b2 < 4)
              w = (op == 8'h02) ? {1'b0, m_r[b1[1:0]]} + {1'b0, m_r[b2[1:0]]}
                                : {1'b0, m_r[b1[1:0]]} - {1'b0, m_r[b2[1:0]]};
            else w = 9'd0;
            res = w[7:0];
            if (b1 < 4) m_r[b1[1:0]] = res;
            m_z = (res == 0); m_c = w[8];
          end
          8'h04: m_pc = {b2, b1};
          default: if (m_z) m_pc = {b2, b1};
        endcase
      end else begin m_h = 1; m_e = 1; m_cyc += 2; end
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  endtask

  task automatic put3(input int a, input logic [7:0] o, input logic [7:0] x, input logic [7:0] y);
    mem[a] = o; mem[a+1] = x; mem[a+2] = y;
  endtask

  int cyc;

  // resets, runs to halt, compares with the model
  task automatic run_prog(input string name);
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk({name, " R1 regs in reset"}, regs_o, 0);
    chk({name, " R1 pc/sp in reset"}, {pc_o, sp_o}, 0);
    chk({name, " R1 flags in reset"}, {zero_o, carry_o, halted_o, error_o}, 0);
    rst_n = 1'b1;
    chk({name, " R10 first read at 0"}, {mem_rd, mem_addr}, {1'b1, 16'h0000});
    cyc = 0;
    while (!halted_o && cyc < 3000) begin
      @(posedge clk); cyc++; @(negedge clk);
    end
    model_run();
    chk({name, " R10 halt cycle"}, cyc, m_cyc);
    chk({name, " R4 regs vs model"}, regs_o, m_regs());
    chk({name, " R2 pc vs model"}, pc_o, m_pc);
    chk({name, " R4 flags vs model"}, {zero_o, carry_o}, {m_z, m_c});
    chk({name, " R9 error vs model"}, {halted_o, error_o}, {m_h, m_e});
  endtask

  task automatic freeze_check(input string name);
    logic [31:0] r0; logic [15:0] p0; logic [3:0] f0; int rd;
    r0 = regs_o; p0 = pc_o; f0 = {zero_o, carry_o, halted_o, error_o}; rd = 0;
    repeat (10) begin @(posedge clk); @(negedge clk); if (mem_rd) rd++; end
    chk({name, " R8 no reads after stop"}, rd, 0);
    chk({name, " R8 state frozen"}, {regs_o, pc_o}, {r0, p0});
    chk({name, " R8 flags frozen"}, {zero_o, carry_o, halted_o, error_o}, f0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));

    // D1: load, subtract with borrow, load keeps flags, halt
    clear_mem();
    put3(0, 8'h01, 0, 5); put3(3, 8'h01, 1, 10); put3(6, 8'h03, 0, 1);
    put3(9, 8'h01, 1, 0); mem[12] = 8'hFF;
    run_prog("D1");
    chk("D1 R4 sub wraps, R3 load", regs_o, 32'h0000_00FB);
    chk("D1 R3 load keeps flags", {zero_o, carry_o}, 2'b01);
    chk("D1 R2 pc after halt", pc_o, 16'd13);
    chk("D1 R10 cycles", cyc, 18);
    freeze_check("D1");

    // D2: add overflow, add to zero
    clear_mem();
    put3(0, 8'h01, 0, 200); put3(3, 8'h01, 1, 100); put3(6, 8'h02, 0, 1);
    put3(9, 8'h01, 2, 128); put3(12, 8'h02, 2, 2); mem[15] = 8'hFF;
    run_prog("D2");
    chk("D2 R4 add overflow", regs_o, 32'h0000_642C);
    chk("D2 R4 zero and carry", {zero_o, carry_o}, 2'b11);

    // D3a: out-of-range destination
    clear_mem();
    put3(0, 8'h01, 0, 7); put3(3, 8'h01, 1, 3); put3(6, 8'h03, 1, 0);
    put3(9, 8'h02, 5, 0); mem[12] = 8'hFF;
    run_prog("D3a");
    chk("D3a R5 regs untouched", regs_o, 32'h0000_FC07);
    chk("D3a R5 zero set carry clear", {zero_o, carry_o}, 2'b10);

    // D3b: out-of-range source zeroes dest; load to index 4 ignored
    clear_mem();
    put3(0, 8'h01, 0, 7); put3(3, 8'h02, 0, 6); put3(6, 8'h01, 4, 99);
    mem[9] = 8'hFF;
    run_prog("D3b");
    chk("D3b R5 R3 regs", regs_o, 32'h0000_0000);
    chk("D3b R5 flags", {zero_o, carry_o}, 2'b10);

    // D4: jumps
    clear_mem();
    put3(0, 8'h01, 0, 1); put3(3, 8'h03, 0, 0); put3(6, 8'h05, 12, 0);
    put3(9, 8'h01, 1, 9); put3(12, 8'h01, 0, 2); put3(15, 8'h02, 0, 0);
    put3(18, 8'h05, 8'h00, 8'h01); put3(21, 8'h01, 2, 5);
    put3(24, 8'h04, 8'h20, 8'h00); put3(27, 8'h01, 3, 7); mem[32] = 8'hFF;
    run_prog("D4");
    chk("D4 R7 R6 regs", regs_o, 32'h0005_0004);
    chk("D4 R6 pc", pc_o, 16'd33);
    chk("D4 R10 cycles", cyc, 34);

    // D5: illegal opcode
    clear_mem();
    put3(0, 8'h01, 0, 5); mem[3] = 8'h00;
    run_prog("D5");
    chk("D5 R9 halted+error", {halted_o, error_o}, 2'b11);
    chk("D5 R9 pc", pc_o, 16'd4);
    freeze_check("D5");

    // random forward-only programs
    for (int t = 0; t < 40; t++) begin
      int n, k;
      clear_mem();
      n = 3 + int'($urandom % 10);
      for (k = 0; k < n; k++) begin
        int kind, tgt;
        kind = int'($urandom % 7);
        tgt = 3 * (k + 1 + int'($urandom % (n - k)));
        case (kind)
          0, 1: put3(3*k, 8'h01, 8'($urandom % 5), 8'($urandom));
          2: put3(3*k, 8'h02, 8'($urandom % 5), 8'($urandom % 5));
          3: put3(3*k, 8'h03, 8'($urandom % 5), 8'($urandom % 5));
          4: put3(3*k, 8'h04, 8'(tgt), 8'(tgt >> 8));
          5: put3(3*k, 8'h05, 8'(tgt), 8'(tgt >> 8));
          default: put3(3*k, 8'h02, 8'($urandom % 4), 8'($urandom % 4));
        endcase
      end
      mem[3*n] = ($urandom % 8 == 0) ? 8'h07 : 8'hFF;
      run_prog("RND");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule